// File: doc/BRIEF.md
# Bus Master Transfer Sequencer

This block sits between a processor-side request port and a simplified PCI-style target port. It takes one request at a time and turns it into a series of data phases. It chooses the 4-bit bus command from the request class (read or write), an active-low burst flag and a memory/I-O attribute. Single-beat requests are carried as 32-bit phases. A burst moves a fixed 32-byte line, starting with 64-bit phases.

When the target turns down a wide phase, the sequencer takes only the low word of that phase. It then finishes the line in 32-bit phases. A phase completes only in a cycle where the target-ready input is high. After the last phase, a one-cycle done pulse is given, and for reads the gathered read data is presented in that same cycle.

Top module: `xfer_seq`

## Requirements
- R1: A write request issues command 4'b0111 when the memory attribute is 1 and 4'b0011 when it is 0, for either value of the burst flag. The command stays constant for the whole transfer.
- R2: A read request with memory attribute 0 issues 4'b0010. With the attribute at 1, it issues 4'b1110 when the active-low burst flag is 0 and 4'b0110 when the flag is 1.
- R3: A single-beat request (burst flag 1) covers the bytes from the address up to address+size-1. Size is 1 to 8, and the bytes never pass an 8-byte boundary. It takes one phase if those bytes lie in one 4-byte word and two phases otherwise. Phase addresses are the word-aligned address of each touched word, in rising order.
- R4: In a single-beat phase, wide-mode request is 0 and byte enables are active low. Bits 3:0 are the inverse of the request's byte mask for that word (bit k means byte k of the word), and bits 7:4 are 1111. The write word is driven on data bits 31:0, taken from request data lane addr[2]*32.
- R5: A burst starts 64-bit phases at the 32-byte aligned line base, with wide request 1, byte enables 8'h00 and 64 data bits per phase. If every phase is accepted wide, it finishes in four phases with the address rising by 8.
- R6: A 64-bit phase accepted while the target's wide-acknowledge is 0 moves only the low word. Every later phase of that burst is 32-bit: wide request 0, byte enables 8'hF0, the word on bits 31:0, and the address rising by 4.
- R7: A phase completes only when target-ready is high. While it is low, address, command, byte enables and data hold.
- R8: Done is high for exactly one cycle, the cycle after the last phase completes. For reads, read-data word w (bits 32w+31:32w) then holds the word returned for line word w, where a single-beat word index is addr[2]. Words that were not read are zero.
- R9: Request-ready is high only while no transfer is in progress. A request is taken in a cycle with valid and ready both high, and the first phase appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_addr | input | 32 | Byte address |
| req_size | input | 4 | Byte count for single-beat requests (1..8) |
| req_write | input | 1 | 1 = write class, 0 = read class |
| req_burst_n | input | 1 | Active-low burst flag |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wdata | input | 256 | Write line; single-beat uses bits 63:0 by byte lane |
| bus_valid | output | 1 | Data phase active |
| bus_cmd | output | 4 | Bus command |
| bus_addr | output | 32 | Phase address |
| bus_be_n | output | 8 | Active-low byte enables |
| bus_req64 | output | 1 | Phase offered as 64-bit |
| bus_wdata | output | 64 | Write data of the phase |
| bus_rdata | input | 64 | Read data from the target |
| t_ready | input | 1 | Target completes the phase this cycle |
| t_ack64 | input | 1 | Target takes the full 64 bits |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 256 | Assembled read data |

## Verification
Two functions can fall in the same clock edge: the fall back to 32-bit phases and the end of the line. When the target turns down width on the final 64-bit beat, that edge has to switch mode and also keep the transfer open for one extra phase, rather than raise done. The bench provokes this by choosing the beat that is turned down (none, first, middle or last) and mixing it with random ready stalls. A reference model walks the line word by word and judges every phase's address, enables, width and data. It also judges the timing of the done pulse and the assembled read line.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
endpackage

// File: rtl/xseq_cmd_sel.sv
module xseq_cmd_sel
    import xseq_pkg::*;
(
    input  logic       is_write,
    input  logic       burst_n,
    input  logic       mem,
    output logic [3:0] cmd
);
    always_comb begin
        if (is_write) begin
            cmd = mem ? CMD_MEM_WR : CMD_IO_WR;
        end else if (!mem) begin
            cmd = CMD_IO_RD;
        end else begin
            cmd = burst_n ? CMD_MEM_RD : CMD_MEM_RDL;
        end
    end
endmodule

// File: rtl/xseq_phase_gen.sv
module xseq_phase_gen #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 8,
    parameter int WIDX_W = 3
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [WIDX_W-1:0]   widx,
    input  logic                mode64,
    input  logic                burst,
    input  logic [7:0]          mask,
    input  logic [WORDS*32-1:0] wline,
    output logic [ADDR_W-1:0]   addr,
    output logic [7:0]          be_n,
    output logic [63:0]         wdata
);
    logic [WIDX_W-1:0] widx_p1;
    logic [31:0]       lo_w;
    logic [31:0]       hi_w;

    assign widx_p1 = widx + 1'b1;
    assign lo_w    = wline[{widx, 5'b0} +: 32];
    assign hi_w    = wline[{widx_p1, 5'b0} +: 32];
    assign addr    = base + ADDR_W'({widx, 2'b00});

    always_comb begin
        if (mode64) begin
            be_n  = 8'h00;
            wdata = {hi_w, lo_w};
        end else begin
            wdata = {32'h0, lo_w};
            if (burst) begin
                be_n = 8'hF0;
            end else if (widx[0]) begin
                be_n = {4'hF, ~mask[7:4]};
            end else begin
                be_n = {4'hF, ~mask[3:0]};
            end
        end
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    localparam int WORDS     = LINE_BYTES / 4,
    localparam int WIDX_W    = $clog2(WORDS),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic              req_write,
    input  logic              req_burst_n,
    input  logic              req_mem,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              bus_valid,
    output logic [3:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_be_n,
    output logic              bus_req64,
    output logic [63:0]       bus_wdata,
    input  logic [63:0]       bus_rdata,
    input  logic              t_ready,
    input  logic              t_ack64,
    output logic              done,
    output logic [LINE_W-1:0] rd_data
);
    typedef struct packed {
        logic              busy;
        logic              mode64;
        logic              burst;
        logic [WIDX_W-1:0] widx;
        logic [WIDX_W-1:0] wlast;
        logic [ADDR_W-1:0] base;
        logic [3:0]        cmd;
        logic [7:0]        mask;
        logic [LINE_W-1:0] wline;
        logic [LINE_W-1:0] rline;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    logic [3:0]        cmd_w;
    logic [15:0]       mask_wide;
    logic [3:0]        end_byte;
    logic [WIDX_W-1:0] widx_p1;
    logic [WIDX_W:0]   widx_nxt;

    xseq_cmd_sel u_cmd (
        .is_write (req_write),
        .burst_n  (req_burst_n),
        .mem      (req_mem),
        .cmd      (cmd_w)
    );

    xseq_phase_gen #(
        .ADDR_W (ADDR_W),
        .WORDS  (WORDS),
        .WIDX_W (WIDX_W)
    ) u_phase (
        .base   (st_q.base),
        .widx   (st_q.widx),
        .mode64 (st_q.mode64),
        .burst  (st_q.burst),
        .mask   (st_q.mask),
        .wline  (st_q.wline),
        .addr   (bus_addr),
        .be_n   (bus_be_n),
        .wdata  (bus_wdata)
    );

    assign mask_wide = ((16'h1 << req_size) - 16'h1) << req_addr[2:0];
    assign end_byte  = {1'b0, req_addr[2:0]} + req_size - 4'd1;
    assign widx_p1   = st_q.widx + 1'b1;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        widx_nxt  = '0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy   = 1'b1;
                st_d.burst  = !req_burst_n;
                st_d.mode64 = !req_burst_n;
                st_d.cmd    = cmd_w;
                st_d.wline  = req_wdata;
                st_d.rline  = '0;
                if (!req_burst_n) begin
                    st_d.base  = req_addr & ~ADDR_W'(LINE_BYTES - 1);
                    st_d.widx  = '0;
                    st_d.wlast = WIDX_W'(WORDS - 1);
                    st_d.mask  = 8'hFF;
                end else begin
                    st_d.base  = {req_addr[ADDR_W-1:3], 3'b000};
                    st_d.widx  = WIDX_W'(req_addr[2]);
                    st_d.wlast = WIDX_W'(end_byte[2]);
                    st_d.mask  = mask_wide[7:0];
                end
            end
        end else if (t_ready) begin
            st_d.rline[{st_q.widx, 5'b0} +: 32] = bus_rdata[31:0];
            if (st_q.mode64 && t_ack64) begin
                st_d.rline[{widx_p1, 5'b0} +: 32] = bus_rdata[63:32];
                widx_nxt = {1'b0, st_q.widx} + 2'd2;
            end else begin
                st_d.mode64 = 1'b0;
                widx_nxt = {1'b0, st_q.widx} + 2'd1;
            end
            if (widx_nxt > {1'b0, st_q.wlast}) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.widx = widx_nxt[WIDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign bus_valid = st_q.busy;
    assign bus_cmd   = st_q.cmd;
    assign bus_req64 = st_q.busy && st_q.mode64;
    assign done      = st_q.done;
    assign rd_data   = st_q.rline;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !t_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wdata));

    p_narrow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_req64 |=> !bus_req64);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_upper_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_req64 |-> bus_be_n[7:4] == 4'hF);

    p_cmd_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && $past(bus_valid) |-> $stable(bus_cmd));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready && !bus_valid);
endmodule

// File: tb/xfer_seq_tb.sv
module xfer_seq_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [3:0]   req_size = '0;
    logic         req_write = 1'b0;
    logic         req_burst_n = 1'b1;
    logic         req_mem = 1'b0;
    logic [255:0] req_wdata = '0;
    logic         bus_valid;
    logic [3:0]   bus_cmd;
    logic [31:0]  bus_addr;
    logic [7:0]   bus_be_n;
    logic         bus_req64;
    logic [63:0]  bus_wdata;
    logic [63:0]  bus_rdata = '0;
    logic         t_ready = 1'b0;
    logic         t_ack64 = 1'b0;
    logic         done;
    logic [255:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_burst_n(req_burst_n), .req_mem(req_mem), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_be_n(bus_be_n), .bus_req64(bus_req64), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .t_ready(t_ready), .t_ack64(t_ack64),
        .done(done), .rd_data(rd_data)
    );

    task automatic report_end();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<190000", cyc);
            report_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input bit wr, input bit bn, input bit mem);
        if (wr) return mem ? 4'b0111 : 4'b0011;
        if (!mem) return 4'b0010;
        return bn ? 4'b0110 : 4'b1110;
    endfunction

    function automatic logic [7:0] byte_mask(input logic [2:0] off, input logic [3:0] sz);
        logic [15:0] m;
        m = ((16'h1 << sz) - 16'h1) << off;
        return m[7:0];
    endfunction

    task automatic run_req(input bit wr, input bit bn, input bit mem, input logic [31:0] addr,
                           input logic [3:0] sz, input int drop_at, input int pct);
        logic [255:0] line, exp_r;
        logic [31:0]  base, ea;
        logic [7:0]   msk, eb;
        logic [63:0]  ew, rd;
        int w, last, n64, nph, guard;
        bit m64, burst, fin, rdy, ack;
        logic [3:0] ec;
        string ctag;
        line = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        burst = !bn;
        ec = exp_cmd(wr, bn, mem);
        ctag = wr ? "R1 cmd" : "R2 cmd";
        msk = byte_mask(addr[2:0], sz);
        if (burst) begin
            base = addr & ~32'd31; w = 0; last = 7;
        end else begin
            base = {addr[31:3], 3'b000}; w = int'(addr[2]);
            last = int'(((addr[2:0] + sz - 1) >> 2) & 1);
        end
        m64 = burst; n64 = 0; nph = 0; fin = 0; guard = 0; exp_r = '0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready when idle", 256'(req_ready), 256'(1));
        req_valid = 1'b1; req_addr = addr; req_size = sz; req_write = wr;
        req_burst_n = bn; req_mem = mem; req_wdata = line;
        @(negedge clk);
        req_valid = 1'b0;
        while (!fin) begin
            guard++;
            if (guard > 3000) begin
                chk(1'b0, "R7 phase never completes", 256'(guard), 256'(0));
                return;
            end
            chk(bus_valid === 1'b1 && req_ready === 1'b0, "R9 busy during transfer",
                256'({bus_valid, req_ready}), 256'(2'b10));
            chk(bus_cmd === ec, ctag, 256'(bus_cmd), 256'(ec));
            ea = base + 32'(4 * w);
            if (m64) begin
                eb = 8'h00; ew = line[(w*32) +: 64];
            end else begin
                ew = {32'h0, line[(w*32) +: 32]};
                if (burst) eb = 8'hF0;
                else eb = {4'hF, (w % 2 == 1) ? ~msk[7:4] : ~msk[3:0]};
            end
            chk(bus_addr === ea, burst ? (m64 ? "R5 addr" : "R6 addr") : "R3 addr", 256'(bus_addr), 256'(ea));
            chk(bus_be_n === eb && bus_req64 === m64,
                burst ? (m64 ? "R5 be/width" : "R6 be/width") : "R4 be/width",
                256'({bus_req64, bus_be_n}), 256'({m64, eb}));
            if (wr) chk(bus_wdata === ew, burst ? (m64 ? "R5 wdata" : "R6 wdata") : "R4 wdata",
                        256'(bus_wdata), 256'(ew));
            rdy = ($urandom % 100) < pct;
            ack = m64 ? (n64 != drop_at) : 1'($urandom);
            rd = {$urandom, $urandom};
            t_ready = rdy; t_ack64 = ack; bus_rdata = rd;
            @(posedge clk);
            if (rdy) begin
                nph++;
                exp_r[w*32 +: 32] = rd[31:0];
                if (m64 && ack) begin
                    exp_r[(w+1)*32 +: 32] = rd[63:32];
                    w += 2; n64++;
                end else begin
                    if (m64) n64++;
                    m64 = 0; w += 1;
                end
                if (w > last) fin = 1;
            end
            @(negedge clk);
            t_ready = 1'b0;
            if (!fin) chk(done === 1'b0, "R8 no early done", 256'(done), 256'(0));
        end
        chk(done === 1'b1 && bus_valid === 1'b0, "R8 done pulse", 256'({done, bus_valid}), 256'(2'b10));
        if (!wr) chk(rd_data === exp_r, "R8 read line", rd_data, exp_r);
        if (!burst) chk(nph == (last - int'(addr[2]) + 1), "R3 phase count", 256'(nph), 256'(last - int'(addr[2]) + 1));
        if (burst && drop_at >= 4) chk(nph == 4, "R5 four wide beats", 256'(nph), 256'(4));
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", 256'(done), 256'(0));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && bus_valid === 1'b0 && done === 1'b0, "R9 reset state",
            256'({req_ready, bus_valid, done}), 256'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && bus_valid === 1'b0, "R9 idle after reset",
            256'({req_ready, bus_valid}), 256'(2'b10));
        run_req(1'b0, 1'b0, 1'b1, 32'h1000_0040, 4'd8, 4, 100);
        run_req(1'b1, 1'b0, 1'b1, 32'h2000_0065, 4'd8, 0, 100);
        run_req(1'b0, 1'b0, 1'b1, 32'h3000_0080, 4'd8, 3, 50);
        run_req(1'b0, 1'b0, 1'b1, 32'h3000_00A0, 4'd8, 1, 70);
        run_req(1'b0, 1'b1, 1'b1, 32'h4000_0004, 4'd4, 4, 100);
        run_req(1'b0, 1'b1, 1'b1, 32'h4000_0003, 4'd2, 4, 100);
        run_req(1'b1, 1'b1, 1'b1, 32'h4000_0008, 4'd8, 4, 60);
        run_req(1'b1, 1'b1, 1'b0, 32'h5000_0001, 4'd1, 4, 100);
        run_req(1'b0, 1'b1, 1'b0, 32'h5000_0006, 4'd2, 4, 100);
        run_req(1'b1, 1'b0, 1'b0, 32'h5000_0100, 4'd8, 4, 100);
        run_req(1'b0, 1'b0, 1'b0, 32'h5000_0120, 4'd8, 2, 100);
        for (int i = 0; i < 160; i++) begin
            bit wr, bn, mem;
            logic [3:0] sz;
            logic [2:0] off;
            logic [31:0] a;
            wr = 1'($urandom); bn = 1'($urandom); mem = 1'($urandom);
            sz = 4'(1 + $urandom % 8);
            off = 3'($urandom % (9 - int'(sz)));
            a = {$urandom} & 32'hFFFF_FFF8;
            a[2:0] = off;
            run_req(wr, bn, mem, a, sz, int'($urandom % 5), 60 + int'($urandom % 41));
        end
        report_end();
    end
endmodule